// File: doc/BRIEF.md
# Tagged Receive Byte Queue

This block is a byte queue between a serial receive deframer and a microprocessor read port. Each stored entry holds a data byte, a 2-bit status code and a flag that marks the byte as the last one of a packet. The oldest entry is always visible on the read side, so software can see a packet boundary before it removes the byte. Fill level, empty and full are reported on every cycle.

Three single-cycle event pulses feed an interrupt collector outside the block. The first fires when a packet-ending byte reaches the head of the queue, or when software reads an empty queue. The second fires when the fill level crosses a threshold, which can be set high or early. The third flags overflow.

A soft clear marks the queue empty without touching storage. A transparent mode changes how overflow behaves: a write to a full queue replaces the newest entry instead of being dropped.

Overflow handling is a two-state machine. The states are `OVF_ARMED` and `OVF_LATCHED`. The machine starts in `OVF_ARMED`. An overflow in transparent mode moves it to `OVF_LATCHED` and emits a pulse. A soft clear moves it from either state back to `OVF_ARMED`. In `OVF_LATCHED`, further transparent overflows give no pulse. Normal-mode overflows pulse in both states.

Top module: `rx_tag_fifo`

## Requirements
- R1: After reset the outputs are: `empty`=1, `full`=0, `level`=0, `rd_data`=0x00, `rd_eop`=0, and `eop_rd_evt`, `fill_evt` and `ovf_evt` all 0.
- R2: `rd_data`, `rd_stat` and `rd_eop` always show the oldest stored entry. `rd_en` on a non-empty queue removes that entry at the clock edge. A write and a read in the same cycle leave `level` unchanged. `level` runs from 0 to 16, and `full` is 1 exactly when `level`=16.
- R3: `eop_rd_evt` is high for one cycle in the cycle where an entry written with `wr_eop`=1 becomes the head. This happens on a write into an empty queue, or on a read that exposes that entry. It does not repeat while the same head stays in place.
- R4: A read of an empty queue leaves `level` at 0 and `rd_data` at 0x00. `eop_rd_evt` is then high in the following cycle.
- R5: With `early_mark`=0, `fill_evt` is high in the cycle where `level` has just moved from 14 to 15. With `early_mark`=1, it is high in the cycle where `level` has just moved from 4 to 5. No other level step raises it.
- R6: With `transp`=0, a write to a full queue without a read is dropped. `level` stays 16, the stored bytes are unchanged, and `ovf_evt` is high in the next cycle for each such write.
- R7: With `transp`=1, a write to a full queue without a read replaces the newest entry. `ovf_evt` pulses for the first such write only. Later transparent overflows give no pulse until a soft clear.
- R8: `soft_rst` makes the queue empty with `level`=0 in the next cycle, and any read or write in that cycle is ignored. Bytes written afterwards are read first. A soft clear re-arms the R7 overflow pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write a byte from the deframer |
| wr_data | input | 8 | Byte to store |
| wr_eop | input | 1 | Byte is the last of a packet |
| wr_stat | input | 2 | Status code stored with the byte |
| rd_en | input | 1 | Remove the head entry |
| rd_data | output | 8 | Head byte, 0x00 when empty |
| rd_eop | output | 1 | Head byte ends a packet |
| rd_stat | output | 2 | Head status code |
| soft_rst | input | 1 | Soft clear: mark the queue empty |
| transp | input | 1 | Transparent mode: overwrite on overflow |
| early_mark | input | 1 | Use the low fill threshold (5) instead of 15 |
| empty | output | 1 | No entries stored |
| full | output | 1 | Sixteen entries stored |
| level | output | 5 | Number of stored entries |
| eop_rd_evt | output | 1 | Packet end at head, or empty read |
| fill_evt | output | 1 | Fill threshold crossed |
| ovf_evt | output | 1 | Overflow pulse |

## Verification
The bench fills the queue to exactly the threshold steps under both `early_mark` settings. A design that compares against the wrong level would fire one entry early or late, or would fire under the wrong setting.

It overflows the queue in both modes and then drains it. A design that overwrote in normal mode, or dropped data in transparent mode, would show the wrong last byte. A design that re-pulses overflow in the latched state would also be caught.

The bench reads an empty queue and parks a tagged byte at the head. A design that leaves the pointers moving on an empty read would return stale bytes. A design that retriggers the head event on every idle cycle would show a pulse where none is expected.

// File: rtl/rxq_pkg.sv
package rxq_pkg;
    localparam int BYTE_W = 8;
    localparam int STAT_W = 2;

    typedef struct packed {
        logic              last;
        logic [STAT_W-1:0] stat;
        logic [BYTE_W-1:0] data;
    } rxq_entry_t;

    typedef enum logic {
        OVF_ARMED,
        OVF_LATCHED
    } ovf_state_e;
endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = $clog2(DEPTH),
    localparam int CW = AW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          ovr,
    input  logic          clr,
    input  rxq_entry_t    wr_ent,
    output rxq_entry_t    head_ent,
    output logic [CW-1:0] count
);
    logic [AW-1:0] wp_q, rp_q;
    logic [CW-1:0] cnt_q;
    logic [AW-1:0] newest_idx;
    rxq_entry_t    mem [DEPTH];

    assign newest_idx = wp_q - 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp_q  <= '0;
            rp_q  <= '0;
            cnt_q <= '0;
        end else if (clr) begin
            rp_q  <= wp_q;
            cnt_q <= '0;
        end else begin
            if (push) wp_q <= wp_q + 1'b1;
            if (pop)  rp_q <= rp_q + 1'b1;
            if (push && !pop)      cnt_q <= cnt_q + 1'b1;
            else if (pop && !push) cnt_q <= cnt_q - 1'b1;
        end
    end

    // One write port per slot; a slot is written on a push to it or when it
    // holds the newest entry and the transparent overwrite is active.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if ((push && wp_q == AW'(g)) || (ovr && newest_idx == AW'(g)))
                mem[g] <= wr_ent;
        end
    end

    assign head_ent = mem[rp_q];
    assign count    = cnt_q;
endmodule

// File: rtl/rxq_evt.sv
module rxq_evt #(
    parameter int DEPTH   = 16,
    parameter int HI_MARK = 15,
    parameter int LO_MARK = 5,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [CW-1:0] level,
    input  logic          early,
    input  logic          head_last,
    input  logic          popped,
    input  logic          empty_rd,
    output logic          fill_evt,
    output logic          eop_rd_evt
);
    localparam logic [CW-1:0] HI = CW'(HI_MARK);
    localparam logic [CW-1:0] LO = CW'(LO_MARK);

    logic [CW-1:0] lvl_q;
    logic          head_last_q, pop_q, empty_rd_q;
    logic [CW-1:0] mark;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lvl_q       <= '0;
            head_last_q <= 1'b0;
            pop_q       <= 1'b0;
            empty_rd_q  <= 1'b0;
        end else begin
            lvl_q       <= level;
            head_last_q <= head_last;
            pop_q       <= popped;
            empty_rd_q  <= empty_rd;
        end
    end

    always_comb begin
        mark       = early ? LO : HI;
        fill_evt   = (lvl_q == mark - 1'b1) && (level == mark);
        // A tagged head is new if the head was untagged or was just replaced.
        eop_rd_evt = (head_last && (!head_last_q || pop_q)) || empty_rd_q;
    end
endmodule

// File: rtl/rxq_ovf_ctl.sv
module rxq_ovf_ctl
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ovf_try,
    input  logic transp,
    output logic ovf_evt
);
    ovf_state_e state_q, state_d;
    logic       pulse_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= OVF_ARMED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        pulse_d = 1'b0;
        unique case (state_q)
            OVF_ARMED: begin
                if (clr) begin
                    state_d = OVF_ARMED;
                end else if (ovf_try) begin
                    pulse_d = 1'b1;
                    if (transp) state_d = OVF_LATCHED;
                end
            end
            OVF_LATCHED: begin
                if (clr)                      state_d = OVF_ARMED;
                else if (ovf_try && !transp)  pulse_d = 1'b1;
            end
            default: state_d = OVF_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ovf_evt <= 1'b0;
        else        ovf_evt <= pulse_d;
    end
endmodule

// File: rtl/rx_tag_fifo.sv
module rx_tag_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH   = 16,
    parameter int HI_MARK = 15,
    parameter int LO_MARK = 5,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              wr_eop,
    input  logic [STAT_W-1:0] wr_stat,
    input  logic              rd_en,
    output logic [BYTE_W-1:0] rd_data,
    output logic              rd_eop,
    output logic [STAT_W-1:0] rd_stat,
    input  logic              soft_rst,
    input  logic              transp,
    input  logic              early_mark,
    output logic              empty,
    output logic              full,
    output logic [CW-1:0]     level,
    output logic              eop_rd_evt,
    output logic              fill_evt,
    output logic              ovf_evt
);
    rxq_entry_t wr_ent, head_ent;
    logic       pop, push, ovr, ovf_try, empty_rd;

    always_comb begin
        empty    = (level == '0);
        full     = (level == CW'(DEPTH));
        pop      = rd_en && !empty && !soft_rst;
        push     = wr_en && !soft_rst && (!full || pop);
        ovf_try  = wr_en && !soft_rst && full && !pop;
        ovr      = ovf_try && transp;
        empty_rd = rd_en && empty && !soft_rst;
        wr_ent   = '{last: wr_eop, stat: wr_stat, data: wr_data};
        rd_data  = empty ? '0 : head_ent.data;
        rd_stat  = empty ? '0 : head_ent.stat;
        rd_eop   = !empty && head_ent.last;
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .push(push), .pop(pop), .ovr(ovr),
        .clr(soft_rst), .wr_ent(wr_ent), .head_ent(head_ent), .count(level)
    );

    rxq_evt #(.DEPTH(DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_evt (
        .clk(clk), .rst_n(rst_n), .level(level), .early(early_mark),
        .head_last(rd_eop), .popped(pop), .empty_rd(empty_rd),
        .fill_evt(fill_evt), .eop_rd_evt(eop_rd_evt)
    );

    rxq_ovf_ctl u_ovf (
        .clk(clk), .rst_n(rst_n), .clr(soft_rst), .ovf_try(ovf_try),
        .transp(transp), .ovf_evt(ovf_evt)
    );
endmodule

// File: rtl/rxq_checker.sv
module rxq_checker #(
    parameter int DEPTH   = 16,
    parameter int HI_MARK = 15,
    parameter int LO_MARK = 5,
    localparam int CW = $clog2(DEPTH) + 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic          rd_en,
    input logic          soft_rst,
    input logic          transp,
    input logic [CW-1:0] level,
    input logic          empty,
    input logic          full,
    input logic          eop_rd_evt,
    input logic          fill_evt,
    input logic          ovf_evt
);
    // R2: level never exceeds the depth
    a_r2_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CW'(DEPTH));

    // R6: a refused write leaves the queue full
    a_r6_stay_full: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en && !rd_en && !soft_rst |=> full);

    // R6: a refused write in normal mode is flagged
    a_r6_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        full && wr_en && !rd_en && !soft_rst && !transp |=> ovf_evt);

    // R4: an empty read raises the packet-end event next cycle
    a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
        empty && rd_en && !soft_rst |=> eop_rd_evt);

    // R8: soft clear empties the queue
    a_r8_soft_clear: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> empty && level == '0);

    // R5: the fill event only appears at one of the two thresholds
    a_r5_fill_mark: assert property (@(posedge clk) disable iff (!rst_n)
        fill_evt |-> (level == CW'(HI_MARK) || level == CW'(LO_MARK)));
endmodule

bind rx_tag_fifo rxq_checker #(.DEPTH(DEPTH), .HI_MARK(HI_MARK), .LO_MARK(LO_MARK)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .soft_rst(soft_rst),
    .transp(transp), .level(level), .empty(empty), .full(full),
    .eop_rd_evt(eop_rd_evt), .fill_evt(fill_evt), .ovf_evt(ovf_evt)
);

// File: tb/sim_rx_tag_fifo.sv
module sim_rx_tag_fifo;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n, wr_en, wr_eop, rd_en, soft_rst, transp, early_mark;
    logic [7:0] wr_data, rd_data;
    logic [1:0] wr_stat, rd_stat;
    logic       rd_eop, empty, full, eop_rd_evt, fill_evt, ovf_evt;
    logic [4:0] level;
    int total = 0;
    int bad   = 0;

    rx_tag_fifo u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .wr_eop(wr_eop),
        .wr_stat(wr_stat), .rd_en(rd_en), .rd_data(rd_data), .rd_eop(rd_eop),
        .rd_stat(rd_stat), .soft_rst(soft_rst), .transp(transp),
        .early_mark(early_mark), .empty(empty), .full(full), .level(level),
        .eop_rd_evt(eop_rd_evt), .fill_evt(fill_evt), .ovf_evt(ovf_evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {wr, eop, rd, data[8], expected level[5], expected head[8]}
    localparam logic [23:0] VEC [9] = '{
        {1'b1, 1'b0, 1'b0, 8'hA1, 5'd1, 8'hA1},
        {1'b1, 1'b1, 1'b0, 8'hB2, 5'd2, 8'hA1},
        {1'b0, 1'b0, 1'b1, 8'h00, 5'd1, 8'hB2},
        {1'b1, 1'b0, 1'b0, 8'hC3, 5'd2, 8'hB2},
        {1'b1, 1'b0, 1'b1, 8'hD4, 5'd2, 8'hC3},
        {1'b0, 1'b0, 1'b1, 8'h00, 5'd1, 8'hD4},
        {1'b0, 1'b0, 1'b1, 8'h00, 5'd0, 8'h00},
        {1'b1, 1'b1, 1'b0, 8'hE5, 5'd1, 8'hE5},
        {1'b0, 1'b0, 1'b1, 8'h00, 5'd0, 8'h00}
    };

    task automatic chk(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic put(input logic w, input logic [7:0] d, input logic e,
                       input logic [1:0] s, input logic r);
        wr_en = w; wr_data = d; wr_eop = e; wr_stat = s; rd_en = r;
        tick();
        wr_en = 1'b0; rd_en = 1'b0;
    endtask

    task automatic sclr();
        soft_rst = 1'b1;
        tick();
        soft_rst = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        total++; bad++;
        $display("FAIL R0 watchdog actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; wr_eop = 1'b0; rd_en = 1'b0; soft_rst = 1'b0;
        transp = 1'b0; early_mark = 1'b0; wr_data = '0; wr_stat = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk("R1", "empty", empty, 1);
        chk("R1", "full", full, 0);
        chk("R1", "level", level, 0);
        chk("R1", "rd_data", rd_data, 0);
        chk("R1", "rd_eop", rd_eop, 0);
        chk("R1", "events", {eop_rd_evt, fill_evt, ovf_evt}, 0);

        // R2 vector table
        for (int i = 0; i < 9; i++) begin
            put(VEC[i][23], VEC[i][20:13], VEC[i][22], 2'b00, VEC[i][21]);
            chk("R2", "level", level, int'(VEC[i][12:8]));
            chk("R2", "head", rd_data, int'(VEC[i][7:0]));
        end

        // R3 tagged head
        sclr();
        put(1'b1, 8'h5A, 1'b1, 2'b10, 1'b0);
        chk("R3", "evt on write", eop_rd_evt, 1);
        chk("R3", "rd_eop", rd_eop, 1);
        chk("R2", "rd_stat", rd_stat, 2);
        put(1'b0, 8'h00, 1'b0, 2'b00, 1'b0);
        chk("R3", "no repeat idle", eop_rd_evt, 0);
        put(1'b1, 8'h6B, 1'b1, 2'b01, 1'b0);
        chk("R3", "no evt behind head", eop_rd_evt, 0);
        put(1'b0, 8'h00, 1'b0, 2'b00, 1'b1);
        chk("R3", "evt on pop", eop_rd_evt, 1);
        chk("R2", "rd_stat next", rd_stat, 1);
        put(1'b0, 8'h00, 1'b0, 2'b00, 1'b1);
        chk("R3", "no evt emptying", eop_rd_evt, 0);

        // R4 empty read
        put(1'b0, 8'h00, 1'b0, 2'b00, 1'b1);
        chk("R4", "evt", eop_rd_evt, 1);
        chk("R4", "level", level, 0);
        chk("R4", "rd_data", rd_data, 0);
        put(1'b0, 8'h00, 1'b0, 2'b00, 1'b0);
        chk("R4", "evt clears", eop_rd_evt, 0);

        // R5 thresholds
        sclr();
        for (int i = 1; i <= 15; i++) begin
            put(1'b1, 8'(i), 1'b0, 2'b00, 1'b0);
            if (i == 5)  chk("R5", "hi mode at 5", fill_evt, 0);
            if (i == 14) chk("R5", "hi mode at 14", fill_evt, 0);
            if (i == 15) chk("R5", "hi mode at 15", fill_evt, 1);
        end
        put(1'b0, 8'h00, 1'b0, 2'b00, 1'b0);
        chk("R5", "hi pulse ends", fill_evt, 0);
        sclr();
        early_mark = 1'b1;
        for (int i = 1; i <= 15; i++) begin
            put(1'b1, 8'(i), 1'b0, 2'b00, 1'b0);
            if (i == 4)  chk("R5", "lo mode at 4", fill_evt, 0);
            if (i == 5)  chk("R5", "lo mode at 5", fill_evt, 1);
            if (i == 15) chk("R5", "lo mode at 15", fill_evt, 0);
        end
        early_mark = 1'b0;

        // R6 normal overflow
        sclr();
        for (int i = 0; i < 16; i++) put(1'b1, 8'h10 + 8'(i), 1'b0, 2'b00, 1'b0);
        chk("R2", "full", full, 1);
        chk("R2", "level 16", level, 16);
        put(1'b1, 8'h99, 1'b0, 2'b00, 1'b0);
        chk("R6", "ovf first", ovf_evt, 1);
        chk("R6", "level held", level, 16);
        put(1'b1, 8'h98, 1'b0, 2'b00, 1'b0);
        chk("R6", "ovf again", ovf_evt, 1);
        put(1'b0, 8'h00, 1'b0, 2'b00, 1'b0);
        chk("R6", "ovf ends", ovf_evt, 0);
        for (int i = 0; i < 16; i++) begin
            chk("R6", "drained byte", rd_data, 8'h10 + i);
            put(1'b0, 8'h00, 1'b0, 2'b00, 1'b1);
        end
        chk("R6", "empty after drain", empty, 1);

        // R7 transparent overflow
        sclr();
        transp = 1'b1;
        for (int i = 0; i < 16; i++) put(1'b1, 8'h40 + 8'(i), 1'b0, 2'b00, 1'b0);
        put(1'b1, 8'hEE, 1'b0, 2'b00, 1'b0);
        chk("R7", "ovf first", ovf_evt, 1);
        chk("R7", "level", level, 16);
        put(1'b1, 8'hEF, 1'b0, 2'b00, 1'b0);
        chk("R7", "no second ovf", ovf_evt, 0);
        for (int i = 0; i < 16; i++) begin
            chk("R7", "drained byte", rd_data, (i == 15) ? 8'hEF : 8'h40 + i);
            put(1'b0, 8'h00, 1'b0, 2'b00, 1'b1);
        end
        for (int i = 0; i < 16; i++) put(1'b1, 8'h60 + 8'(i), 1'b0, 2'b00, 1'b0);
        put(1'b1, 8'hE0, 1'b0, 2'b00, 1'b0);
        chk("R7", "still latched", ovf_evt, 0);

        // R8 soft clear
        soft_rst = 1'b1; wr_en = 1'b1; wr_data = 8'h77; rd_en = 1'b1;
        tick();
        soft_rst = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        chk("R8", "level", level, 0);
        chk("R8", "empty", empty, 1);
        put(1'b1, 8'h3C, 1'b0, 2'b00, 1'b0);
        chk("R8", "new byte first", rd_data, 8'h3C);
        for (int i = 0; i < 15; i++) put(1'b1, 8'(i), 1'b0, 2'b00, 1'b0);
        put(1'b1, 8'hE1, 1'b0, 2'b00, 1'b0);
        chk("R8", "rearmed ovf", ovf_evt, 1);
        transp = 1'b0;

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule